// File: doc/BRIEF.md
# Fully Associative Tag Store with Live Occupancy

This block keeps a small set of address/data pairs in a single set of `WAYS` entries, where any entry can hold any address and no address is stored twice. Several fill ports write, update or drop entries, and several read ports look entries up by address in the same cycle. A lookup can also retire the entry it finds, which suits tracking of outstanding requests: the request address is filled when the request leaves, and the response looks it up and retires it in a single access.

A fill whose address is absent takes the lowest-numbered free entry. When no entry is free, a round-robin cursor picks a victim, and the displaced pair is reported on the eviction outputs that belong to the same fill port. A registered count of live entries, with full and empty flags, lets upstream logic hold off new requests. No port is ever refused, so there is no ready signal. Upstream logic applies back-pressure by watching `occ_full`, or by accepting that an eviction will occur.

Top module: `assoc_track_cache`

## Requirements
- R1: A read port with `rd_en` high returns `rd_hit`=1 in the same cycle when its address matches a live entry, and `rd_data` then carries that entry's data. When the address misses, or when `rd_en` is low, `rd_hit`=0 and `rd_data`=0.
- R2: A valid fill (`fill_en`=1, `fill_valid`=1) whose address is absent stores the pair in the lowest-indexed free entry. The pair can be read from the next cycle on.
- R3: A fill with `fill_en`=1 and `fill_valid`=0 removes the entry that matches its address after the clock edge. If the address is absent, the fill has no effect.
- R4: A read with `rd_en`=1 and `rd_inv`=1 that hits removes the entry after the clock edge. A miss with `rd_inv`=1 leaves the contents unchanged.
- R5: A valid fill whose address is already live overwrites that entry's data in place. It raises no eviction and leaves the count unchanged.
- R6: Valid fills to distinct new addresses in the same cycle take distinct entries in port order, so port 0 gets the lower free index.
- R7: A valid fill of a new address evicts only when no free entry remains after lower-numbered ports have allocated. In that case `ev_valid`, `ev_addr` and `ev_data` of the same port index show the displaced pair in that same cycle, and they read 0 otherwise. To pick the victim, the cursor scans upward from its current index, wrapping round, and takes the first entry not already claimed in that cycle. The cursor then moves to one past that victim. The cursor starts at 0 after reset.
- R8: After each clock edge, `occ_count` equals the number of live entries. `occ_full`=1 exactly when the count equals `WAYS`, and `occ_empty`=1 exactly when the count is 0.
- R9: A read in the same cycle as a fill of the same address sees the contents from before that fill.
- R10: During and after reset, all entries are empty, the count is 0, `occ_empty`=1, `occ_full`=0 and every hit and eviction output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fill_en | input | NFILL | Fill request per port |
| fill_valid | input | NFILL | 1 = write/allocate, 0 = remove matching entry |
| fill_addr | input | NFILL x ADDR_W | Fill address per port |
| fill_data | input | NFILL x DATA_W | Fill data per port |
| rd_en | input | NREAD | Lookup request per port |
| rd_inv | input | NREAD | Retire the entry on a hit |
| rd_addr | input | NREAD x ADDR_W | Lookup address per port |
| rd_hit | output | NREAD | Lookup found a live entry |
| rd_data | output | NREAD x DATA_W | Data of the matching entry, 0 on a miss |
| ev_valid | output | NFILL | Fill on this port displaced an entry |
| ev_addr | output | NFILL x ADDR_W | Displaced address |
| ev_data | output | NFILL x DATA_W | Displaced data |
| occ_count | output | clog2(WAYS+1) | Number of live entries |
| occ_full | output | 1 | All entries live |
| occ_empty | output | 1 | No entry live |

## Verification
The checks on single-entry hits and on allocation take for granted that fill ports in one cycle never carry the same address. They also assume that no address is allocated by one port while another port removes it in that cycle. Under those conditions every address maps to at most one entry. The stimulus gives each fill port a different address in every multi-port cycle, and it only retires addresses that no fill touches in that cycle. The eviction check assumes no fill drops an entry in the same cycle as an eviction, and the stimulus keeps drops and evictions in separate cycles.

// File: rtl/assoc_cache_pkg.sv
package assoc_cache_pkg;

  // Index width for n items; never narrower than one bit.
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/act_tag_match.sv
module act_tag_match #(
  parameter int WAYS   = 4,
  parameter int ADDR_W = 8
) (
  input  logic [WAYS-1:0]             way_live,
  input  logic [WAYS-1:0][ADDR_W-1:0] way_tag,
  input  logic [ADDR_W-1:0]           key,
  output logic [WAYS-1:0]             hit_vec,
  output logic                        any_hit
);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = way_live[w] && (way_tag[w] == key);
  end

  assign any_hit = |hit_vec;

endmodule

// File: rtl/act_way_alloc.sv
module act_way_alloc #(
  parameter int WAYS  = 4,
  parameter int NFILL = 2,
  parameter int IW    = assoc_cache_pkg::idx_bits(WAYS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [WAYS-1:0]            way_live,
  input  logic [WAYS-1:0]            busy,
  input  logic [NFILL-1:0]           need,
  input  logic [IW-1:0]              rr_ptr,
  output logic [NFILL-1:0][WAYS-1:0] grant,
  output logic [NFILL-1:0]           evict,
  output logic [NFILL-1:0][IW-1:0]   victim,
  output logic [IW-1:0]              rr_next
);

  logic [WAYS-1:0] claimed;
  logic [WAYS-1:0] freeset;
  logic            found;
  int              cur;
  int              cand;

  always_comb begin
    claimed = busy;
    freeset = ~way_live;
    cur     = int'(rr_ptr);
    cand    = 0;
    grant   = '0;
    evict   = '0;
    victim  = '0;
    found   = 1'b0;
    for (int f = 0; f < NFILL; f++) begin
      found = 1'b0;
      if (need[f]) begin
        for (int w = 0; w < WAYS; w++) begin
          if (!found && freeset[w]) begin
            grant[f][w] = 1'b1;
            freeset[w]  = 1'b0;
            claimed[w]  = 1'b1;
            found       = 1'b1;
          end
        end
        for (int k = 0; k < WAYS; k++) begin
          cand = (cur + k) % WAYS;
          if (!found && !claimed[cand]) begin
            grant[f][cand] = 1'b1;
            claimed[cand]  = 1'b1;
            evict[f]       = 1'b1;
            victim[f]      = IW'(cand);
            found          = 1'b1;
          end
        end
        if (evict[f]) cur = (int'(victim[f]) + 1) % WAYS;
      end
    end
    rr_next = IW'(cur);
  end

  for (genvar f = 0; f < NFILL; f++) begin : g_chk
    AST_EVICT_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      evict[f] |-> ($countones(~way_live) <= f)); // R7
    AST_ONE_WAY_PER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant[f])); // R6
  end

endmodule

// File: rtl/assoc_track_cache.sv
module assoc_track_cache #(
  parameter int WAYS   = 4,
  parameter int NFILL  = 2,
  parameter int NREAD  = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NFILL-1:0]              fill_en,
  input  logic [NFILL-1:0]              fill_valid,
  input  logic [NFILL-1:0][ADDR_W-1:0]  fill_addr,
  input  logic [NFILL-1:0][DATA_W-1:0]  fill_data,
  input  logic [NREAD-1:0]              rd_en,
  input  logic [NREAD-1:0]              rd_inv,
  input  logic [NREAD-1:0][ADDR_W-1:0]  rd_addr,
  output logic [NREAD-1:0]              rd_hit,
  output logic [NREAD-1:0][DATA_W-1:0]  rd_data,
  output logic [NFILL-1:0]              ev_valid,
  output logic [NFILL-1:0][ADDR_W-1:0]  ev_addr,
  output logic [NFILL-1:0][DATA_W-1:0]  ev_data,
  output logic [$clog2(WAYS+1)-1:0]     occ_count,
  output logic                          occ_full,
  output logic                          occ_empty
);

  localparam int IW = assoc_cache_pkg::idx_bits(WAYS);
  localparam int CW = $clog2(WAYS + 1);

  logic [WAYS-1:0]             live_q, live_d;
  logic [WAYS-1:0][ADDR_W-1:0] tag_q;
  logic [WAYS-1:0][DATA_W-1:0] dat_q;
  logic [IW-1:0]               rr_q, rr_d;
  logic [CW-1:0]               occ_q, occ_d;

  logic [NREAD-1:0][WAYS-1:0]  rd_vec;
  logic [NREAD-1:0]            rd_any;
  logic [NFILL-1:0][WAYS-1:0]  fl_vec;
  logic [NFILL-1:0]            fl_any;
  logic [NFILL-1:0]            need;
  logic [WAYS-1:0]             busy;
  logic [NFILL-1:0][WAYS-1:0]  grant;
  logic [NFILL-1:0]            evict;
  logic [NFILL-1:0][IW-1:0]    victim;

  logic [WAYS-1:0]             wr_en, clr;
  logic [WAYS-1:0][ADDR_W-1:0] wr_tag;
  logic [WAYS-1:0][DATA_W-1:0] wr_dat;

  // Lookup side: combinational against current contents.
  for (genvar r = 0; r < NREAD; r++) begin : g_rd
    act_tag_match #(.WAYS(WAYS), .ADDR_W(ADDR_W)) u_rm (
      .way_live (live_q),
      .way_tag  (tag_q),
      .key      (rd_addr[r]),
      .hit_vec  (rd_vec[r]),
      .any_hit  (rd_any[r])
    );
    assign rd_hit[r] = rd_en[r] && rd_any[r];
    always_comb begin
      rd_data[r] = '0;
      for (int w = 0; w < WAYS; w++)
        if (rd_en[r] && rd_vec[r][w]) rd_data[r] = rd_data[r] | dat_q[w];
    end
    AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_vec[r])); // R1
  end

  // Fill side: match, then allocate new addresses.
  for (genvar f = 0; f < NFILL; f++) begin : g_fl
    act_tag_match #(.WAYS(WAYS), .ADDR_W(ADDR_W)) u_fm (
      .way_live (live_q),
      .way_tag  (tag_q),
      .key      (fill_addr[f]),
      .hit_vec  (fl_vec[f]),
      .any_hit  (fl_any[f])
    );
    assign need[f]     = fill_en[f] && fill_valid[f] && !fl_any[f];
    assign ev_valid[f] = evict[f];
    assign ev_addr[f]  = evict[f] ? tag_q[victim[f]] : '0;
    assign ev_data[f]  = evict[f] ? dat_q[victim[f]] : '0;
  end

  always_comb begin
    busy = '0;
    for (int f = 0; f < NFILL; f++)
      if (fill_en[f] && fill_valid[f]) busy = busy | fl_vec[f];
  end

  act_way_alloc #(.WAYS(WAYS), .NFILL(NFILL), .IW(IW)) u_alloc (
    .clk      (clk),
    .rst_n    (rst_n),
    .way_live (live_q),
    .busy     (busy),
    .need     (need),
    .rr_ptr   (rr_q),
    .grant    (grant),
    .evict    (evict),
    .victim   (victim),
    .rr_next  (rr_d)
  );

  // Next-state decode: writes win over removals on the same entry.
  always_comb begin
    wr_en  = '0;
    wr_tag = '0;
    wr_dat = '0;
    clr    = '0;
    for (int f = 0; f < NFILL; f++) begin
      if (fill_en[f] && fill_valid[f]) begin
        for (int w = 0; w < WAYS; w++) begin
          if (fl_vec[f][w] || grant[f][w]) begin
            wr_en[w]  = 1'b1;
            wr_tag[w] = fill_addr[f];
            wr_dat[w] = fill_data[f];
          end
        end
      end else if (fill_en[f]) begin
        clr = clr | fl_vec[f];
      end
    end
    for (int r = 0; r < NREAD; r++)
      if (rd_en[r] && rd_inv[r]) clr = clr | rd_vec[r];
    live_d = wr_en | (live_q & ~clr);
    occ_d  = CW'(int'(occ_q) + $countones(live_d & ~live_q)
                 - $countones(live_q & ~live_d));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      tag_q  <= '0;
      dat_q  <= '0;
      rr_q   <= '0;
      occ_q  <= '0;
    end else begin
      live_q <= live_d;
      rr_q   <= rr_d;
      occ_q  <= occ_d;
      for (int w = 0; w < WAYS; w++) begin
        if (wr_en[w]) begin
          tag_q[w] <= wr_tag[w];
          dat_q[w] <= wr_dat[w];
        end
      end
    end
  end

  assign occ_count = occ_q;
  assign occ_full  = (occ_q == CW'(WAYS));
  assign occ_empty = (occ_q == '0);

  AST_COUNT_TRACKS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q == CW'($countones(live_q))); // R8

  for (genvar w = 0; w < WAYS; w++) begin : g_way_chk
    AST_REMOVE_TAKES_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[w] && !wr_en[w]) |=> !live_q[w]); // R4
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[w] |=> (live_q[w] && tag_q[w] == $past(wr_tag[w]))); // R2
  end

endmodule

// File: tb/sim_assoc_track_cache.sv
module sim_assoc_track_cache;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]       fill_en, fill_valid, rd_en, rd_inv;
  logic [1:0][7:0]  fill_addr, rd_addr;
  logic [1:0][15:0] fill_data;
  logic [1:0]       rd_hit, ev_valid;
  logic [1:0][15:0] rd_data, ev_data;
  logic [1:0][7:0]  ev_addr;
  logic [2:0]       occ_count;
  logic             occ_full, occ_empty;

  int checks = 0;
  int errors = 0;

  assoc_track_cache #(.WAYS(4), .NFILL(2), .NREAD(2), .ADDR_W(8), .DATA_W(16)) u0 (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_en), .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .rd_en(rd_en), .rd_inv(rd_inv), .rd_addr(rd_addr),
    .rd_hit(rd_hit), .rd_data(rd_data),
    .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_data(ev_data),
    .occ_count(occ_count), .occ_full(occ_full), .occ_empty(occ_empty)
  );

  typedef struct packed {
    logic fe; logic fv; logic [7:0] fa; logic [15:0] fd;
    logic re; logic ri; logic [7:0] ra;
    logic xh; logic [15:0] xd;
    logic xe; logic [7:0] xea; logic [15:0] xed;
    logic [2:0] xo;
  } vec_t;

  // Port 0 only. Columns: fill en/valid/addr/data, read en/inv/addr,
  // expected hit/data, expected evict/addr/data, expected count after edge.
  localparam vec_t VECS [16] = '{
    '{1'b1,1'b1,8'h10,16'hA010, 1'b1,1'b0,8'h10, 1'b0,16'h0,    1'b0,8'h00,16'h0,    3'd1}, // R9 old contents, R2
    '{1'b0,1'b0,8'h00,16'h0,    1'b1,1'b0,8'h10, 1'b1,16'hA010, 1'b0,8'h00,16'h0,    3'd1}, // R1
    '{1'b1,1'b1,8'h20,16'hA020, 1'b0,1'b0,8'h00, 1'b0,16'h0,    1'b0,8'h00,16'h0,    3'd2}, // R2
    '{1'b1,1'b1,8'h30,16'hA030, 1'b0,1'b0,8'h00, 1'b0,16'h0,    1'b0,8'h00,16'h0,    3'd3},
    '{1'b1,1'b1,8'h40,16'hA040, 1'b0,1'b0,8'h00, 1'b0,16'h0,    1'b0,8'h00,16'h0,    3'd4}, // R8 full
    '{1'b1,1'b1,8'h20,16'hB020, 1'b0,1'b0,8'h00, 1'b0,16'h0,    1'b0,8'h00,16'h0,    3'd4}, // R5 overwrite
    '{1'b0,1'b0,8'h00,16'h0,    1'b1,1'b0,8'h20, 1'b1,16'hB020, 1'b0,8'h00,16'h0,    3'd4}, // R5
    '{1'b1,1'b1,8'h50,16'hA050, 1'b0,1'b0,8'h00, 1'b0,16'h0,    1'b1,8'h10,16'hA010, 3'd4}, // R7 way 0 first
    '{1'b1,1'b1,8'h60,16'hA060, 1'b0,1'b0,8'h00, 1'b0,16'h0,    1'b1,8'h20,16'hB020, 3'd4}, // R7 way 1 next
    '{1'b0,1'b0,8'h00,16'h0,    1'b1,1'b0,8'h10, 1'b0,16'h0,    1'b0,8'h00,16'h0,    3'd4}, // R1 miss
    '{1'b1,1'b0,8'h30,16'h0,    1'b0,1'b0,8'h00, 1'b0,16'h0,    1'b0,8'h00,16'h0,    3'd3}, // R3 remove
    '{1'b1,1'b0,8'h99,16'h0,    1'b0,1'b0,8'h00, 1'b0,16'h0,    1'b0,8'h00,16'h0,    3'd3}, // R3 absent
    '{1'b0,1'b0,8'h00,16'h0,    1'b1,1'b1,8'h40, 1'b1,16'hA040, 1'b0,8'h00,16'h0,    3'd2}, // R4 retire
    '{1'b0,1'b0,8'h00,16'h0,    1'b1,1'b0,8'h40, 1'b0,16'h0,    1'b0,8'h00,16'h0,    3'd2}, // R4 gone
    '{1'b0,1'b0,8'h00,16'h0,    1'b1,1'b1,8'h77, 1'b0,16'h0,    1'b0,8'h00,16'h0,    3'd2}, // R4 miss
    '{1'b0,1'b0,8'h00,16'h0,    1'b1,1'b0,8'h50, 1'b1,16'hA050, 1'b0,8'h00,16'h0,    3'd2}  // R4 others kept
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    fill_en = '0; fill_valid = '0; fill_addr = '0; fill_data = '0;
    rd_en = '0; rd_inv = '0; rd_addr = '0;
  endtask

  task automatic chk_occ(input string req, input int n);
    chk(req, 32'(occ_count), 32'(n));
    chk(req, 32'(occ_full), 32'(n == 4));
    chk(req, 32'(occ_empty), 32'(n == 0));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1;
    // R10: outputs while held in reset
    chk_occ("R10", 0);
    chk("R10 hit", 32'(rd_hit), 0);
    chk("R10 evict", 32'(ev_valid), 0);
    @(negedge clk); rst_n = 1'b1;

    foreach (VECS[i]) begin
      @(negedge clk);
      idle();
      fill_en[0] = VECS[i].fe; fill_valid[0] = VECS[i].fv;
      fill_addr[0] = VECS[i].fa; fill_data[0] = VECS[i].fd;
      rd_en[0] = VECS[i].re; rd_inv[0] = VECS[i].ri; rd_addr[0] = VECS[i].ra;
      #1;
      chk("R1 hit", 32'(rd_hit[0]), 32'(VECS[i].xh));
      chk("R1 data", 32'(rd_data[0]), 32'(VECS[i].xd));
      chk("R7 ev_valid", 32'(ev_valid[0]), 32'(VECS[i].xe));
      chk("R7 ev_addr", 32'(ev_addr[0]), 32'(VECS[i].xea));
      chk("R7 ev_data", 32'(ev_data[0]), 32'(VECS[i].xed));
      @(posedge clk); #1;
      chk_occ("R8", int'(VECS[i].xo));
    end

    // R6: two fills in one cycle take ways 2 and 3 in port order
    @(negedge clk); idle();
    fill_en = 2'b11; fill_valid = 2'b11;
    fill_addr[0] = 8'h70; fill_data[0] = 16'hC070;
    fill_addr[1] = 8'h80; fill_data[1] = 16'hC080;
    #1; chk("R6 no evict", 32'(ev_valid), 0);
    @(posedge clk); #1; chk_occ("R6", 4);

    // R6: cursor sits at 2, so port 0's entry (0x70) must be way 2
    @(negedge clk); idle();
    fill_en[0] = 1'b1; fill_valid[0] = 1'b1; fill_addr[0] = 8'h90; fill_data[0] = 16'hC090;
    #1;
    chk("R6 ev_addr", 32'(ev_addr[0]), 32'h70);
    chk("R7 ev_data", 32'(ev_data[0]), 32'hC070);

    // R7: eviction reported on the port that filled
    @(negedge clk); idle();
    fill_en[1] = 1'b1; fill_valid[1] = 1'b1; fill_addr[1] = 8'hA0; fill_data[1] = 16'hC0A0;
    #1;
    chk("R7 port0 quiet", 32'(ev_valid[0]), 0);
    chk("R7 port1 valid", 32'(ev_valid[1]), 1);
    chk("R7 port1 addr", 32'(ev_addr[1]), 32'h80);

    // R7: two evictions in one cycle, cursor wrapped to 0
    @(negedge clk); idle();
    fill_en = 2'b11; fill_valid = 2'b11;
    fill_addr[0] = 8'hB0; fill_data[0] = 16'hC0B0;
    fill_addr[1] = 8'hC0; fill_data[1] = 16'hC0C0;
    #1;
    chk("R7 dual ev0", 32'(ev_addr[0]), 32'h50);
    chk("R7 dual ev0 data", 32'(ev_data[0]), 32'hA050);
    chk("R7 dual ev1", 32'(ev_addr[1]), 32'h60);
    chk("R7 dual ev1 data", 32'(ev_data[1]), 32'hA060);
    @(posedge clk); #1; chk_occ("R7 count kept", 4);

    // R1: read port 1 disabled on a live address
    @(negedge clk); idle();
    rd_en[0] = 1'b1; rd_addr[0] = 8'hB0; rd_addr[1] = 8'hC0;
    #1;
    chk("R1 port0 hit", 32'(rd_hit[0]), 1);
    chk("R1 port0 data", 32'(rd_data[0]), 32'hC0B0);
    chk("R1 disabled hit", 32'(rd_hit[1]), 0);
    chk("R1 disabled data", 32'(rd_data[1]), 0);

    // R3/R4/R8: drop all four entries at once
    @(negedge clk); idle();
    rd_en = 2'b11; rd_inv = 2'b11; rd_addr[0] = 8'hB0; rd_addr[1] = 8'hC0;
    fill_en = 2'b11; fill_valid = 2'b00; fill_addr[0] = 8'h90; fill_addr[1] = 8'hA0;
    #1;
    chk("R4 port1 hit", 32'(rd_hit[1]), 1);
    chk("R4 port1 data", 32'(rd_data[1]), 32'hC0C0);
    @(posedge clk); #1; chk_occ("R8 empty", 0);

    // R10: reset clears a live entry
    @(negedge clk); idle();
    fill_en[0] = 1'b1; fill_valid[0] = 1'b1; fill_addr[0] = 8'h11; fill_data[0] = 16'h1111;
    @(negedge clk); idle();
    rst_n = 1'b0;
    #1; chk_occ("R10 reset", 0);
    @(negedge clk); rst_n = 1'b1;
    rd_en[0] = 1'b1; rd_addr[0] = 8'h11;
    #1; chk("R10 entry gone", 32'(rd_hit[0]), 0);
    @(negedge clk); idle();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule